// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt events from eight sources onto six request lines and turns the winning request into a timed acknowledge sequence for a small CPU core. The sources are four port pins, a serial-receive event, a serial-transmit event and two timer events. A rising edge on a source latches the bit of its line in a request register. Software can read that register, and it can also write it to raise or drop requests by program. A per-line mask and one global enable decide which pending requests are eligible. A six-bit priority code sets the order in which eligible lines win.

The core pulses an instruction-boundary strobe at the end of every instruction. On that strobe, if any request is eligible, the block grants the winner. The grant clears the global enable and the winner's request bit. The block then runs a fixed 57-cycle acknowledge sequence. During the sequence it pulses strobes that tell the core when to push the two program-counter bytes and the flags. It then pulses two more strobes, one for each of the two vector bytes, and drives the address of each byte as it is fetched. A final pulse marks the cycle just before the first fetch of the service routine. Stack memory and program memory lie outside the block and are seen only through these strobes.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Sources map to lines as follows: sources 0, 1 and 2 go to lines 0, 1 and 2. Source 3 (port pin) and source 4 (serial receive) go to line 3. Source 5 (serial transmit) and source 6 (timer 0) go to line 4. Source 7 (timer 1) goes to line 5. A 0-to-1 change on a source sets its line's request bit at the next clock edge. A source held high does not set the bit again.
- R2: A register write with `reg_sel`=0 loads the request register from `reg_wdata[5:0]`. A 1 bit sets a request and a 0 bit clears it. Reads with `reg_sel`=0 return `{2'b00, request}`.
- R3: If a hardware set and a software clear of the same request bit arrive in the same cycle, the bit ends up set.
- R4: A write with `reg_sel`=1 loads the global enable from bit 7 and the per-line mask from bits 5:0. A read returns `{enable, 1'b0, mask}`. A request is granted only if its mask bit and the global enable are both 1. A request that is masked or not enabled stays visible in the request register.
- R5: A write with `reg_sel`=2 loads the 6-bit priority code, and a read returns `{2'b00, code}`. The lines form three groups: G0 = {0,1}, G1 = {2,3} and G2 = {4,5}. Code bits 2:0 set the group order: 1 gives G0>G1>G2, 2 gives G0>G2>G1, 3 gives G1>G0>G2, 4 gives G1>G2>G0, 5 gives G2>G0>G1 and 6 gives G2>G1>G0. Bits 3, 4 and 5 put the odd line first within G0, G1 and G2 respectively. Codes 0 and 7 give the fixed order line 0 (highest) to line 5 (lowest), and the swap bits have no effect.
- R6: A grant happens only at the clock edge where `insn_end` is 1. The grant clears the global enable and the winner's request bit and leaves all other request bits unchanged. From the next cycle, `grant_id` shows the winner.
- R7: Call the sampling edge cycle 0. Then `busy` is 1 in cycles 1 to 57. `push_pc_lo` pulses in cycle 16, `push_pc_hi` in cycle 32, `push_flags` in cycle 48, `fetch_vec_hi` in cycle 52, `fetch_vec_lo` in cycle 56 and `done` in cycle 57. Each pulse lasts one cycle.
- R8: `vec_addr` is 2×n in the `fetch_vec_hi` cycle and 2×n+1 in the `fetch_vec_lo` cycle, where n is the granted line.
- R9: While `busy` is 1, `insn_end` starts no new grant, even if software sets the global enable again. The running sequence keeps its timing, and `grant_id` and the request bits are unchanged.
- R10: After reset, the request, mask, enable and priority registers are all 0. `busy`, `grant_id` and all phase strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_evt | input | 8 | Event sources: 0-3 port pins, 4 serial receive, 5 serial transmit, 6-7 timers |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 request, 1 mask and enable, 2 priority |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| insn_end | input | 1 | Instruction-boundary strobe from the core |
| busy | output | 1 | Acknowledge sequence running |
| grant_id | output | 3 | Line number of the last grant |
| vec_addr | output | 8 | Vector byte address during vector fetch |
| push_pc_lo | output | 1 | Push program-counter low byte |
| push_pc_hi | output | 1 | Push program-counter high byte |
| push_flags | output | 1 | Push flag register |
| fetch_vec_hi | output | 1 | Fetch high byte of vector |
| fetch_vec_lo | output | 1 | Fetch low byte of vector |
| done | output | 1 | Last sequence cycle; service routine fetch follows |

## Verification
Two pairs of events can land in the same cycle. A hardware edge can arrive together with a software write that clears the same request bit, and an `insn_end` can arrive in the middle of a running sequence together with a write that sets the global enable again. The bench provokes the first pair by driving the source edge and the clearing write on the same falling edge. It then reads the request register and expects the bit to be set. It provokes the second pair by issuing the write and the strobe together in cycle 5 of a sequence. It expects the strobe timing, `grant_id` and the remaining request bits to be unchanged, and the enable written by software to read back as 1.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
  localparam int NLINES = 6;
  localparam int NSRC   = 8;
  localparam int ID_W   = $clog2(NLINES);
  localparam int PRIO_W = 6;
  localparam int NGRP   = NLINES / 2;

  typedef logic [ID_W-1:0]   id_t;
  typedef id_t [NLINES-1:0]  rank_t;

  // rank[0] is the highest-priority line for a given code.
  function automatic rank_t rank_of(input logic [PRIO_W-1:0] code);
    rank_t      r;
    logic [1:0] grp [NGRP];
    logic       fallback;
    logic       swp;
    fallback = 1'b0;
    grp[0] = 2'd0; grp[1] = 2'd1; grp[2] = 2'd2;
    case (code[2:0])
      3'd1: begin grp[0] = 2'd0; grp[1] = 2'd1; grp[2] = 2'd2; end
      3'd2: begin grp[0] = 2'd0; grp[1] = 2'd2; grp[2] = 2'd1; end
      3'd3: begin grp[0] = 2'd1; grp[1] = 2'd0; grp[2] = 2'd2; end
      3'd4: begin grp[0] = 2'd1; grp[1] = 2'd2; grp[2] = 2'd0; end
      3'd5: begin grp[0] = 2'd2; grp[1] = 2'd0; grp[2] = 2'd1; end
      3'd6: begin grp[0] = 2'd2; grp[1] = 2'd1; grp[2] = 2'd0; end
      default: fallback = 1'b1;
    endcase
    for (int gi = 0; gi < NGRP; gi++) begin
      swp = code[3 + int'(grp[gi])];
      r[2*gi]   = id_t'({grp[gi],  swp});
      r[2*gi+1] = id_t'({grp[gi], ~swp});
    end
    if (fallback) begin
      for (int i = 0; i < NLINES; i++) r[i] = id_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_vc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic              wr_req,
  input  logic              wr_mask,
  input  logic              wr_prio,
  input  logic [7:0]        wdata,
  input  logic              grant,
  input  id_t               grant_line,
  output logic [NLINES-1:0] req_q,
  output logic [NLINES-1:0] mask_q,
  output logic              gie_q,
  output logic [PRIO_W-1:0] prio_q
);
  logic [NSRC-1:0]   src_q;
  logic [NSRC-1:0]   src_edge;
  logic [NLINES-1:0] line_set;
  logic [NLINES-1:0] grant_clr;
  logic [NLINES-1:0] req_n;
  logic [NLINES-1:0] mask_n;
  logic              gie_n;
  logic              req_en;
  logic              mask_en;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[6];
  assign src_edge = src_evt & ~src_q;

  // Eight sources folded onto six lines.
  assign line_set[0] = src_edge[0];
  assign line_set[1] = src_edge[1];
  assign line_set[2] = src_edge[2];
  assign line_set[3] = src_edge[3] | src_edge[4];
  assign line_set[4] = src_edge[5] | src_edge[6];
  assign line_set[5] = src_edge[7];

  assign grant_clr = grant ? (NLINES'(1) << grant_line) : '0;

  always_comb begin
    req_n = req_q;
    if (wr_req) req_n = wdata[NLINES-1:0];
    req_n = (req_n & ~grant_clr) | line_set;
  end
  assign req_en = wr_req | grant | (|line_set);

  always_comb begin
    mask_n = mask_q;
    gie_n  = gie_q;
    if (wr_mask) begin
      mask_n = wdata[NLINES-1:0];
      gie_n  = wdata[7];
    end
    if (grant) gie_n = 1'b0;
  end
  assign mask_en = wr_mask | grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      req_q  <= '0;
      mask_q <= '0;
      gie_q  <= 1'b0;
      prio_q <= '0;
    end else begin
      src_q <= src_evt;
      if (req_en)  req_q <= req_n;
      if (mask_en) begin
        mask_q <= mask_n;
        gie_q  <= gie_n;
      end
      if (wr_prio) prio_q <= wdata[PRIO_W-1:0];
    end
  end

  // R3: a hardware edge always leaves its bit set, whatever else happened.
  p_hw_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_set) |=> ((req_q & $past(line_set)) == $past(line_set)));

  // R6: the granted bit drops unless a fresh edge re-raised it.
  p_grant_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !line_set[grant_line]) |=> !req_q[$past(grant_line)]);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_vc_pkg::*;
(
  input  logic [NLINES-1:0] elig,
  input  logic [PRIO_W-1:0] code,
  output logic              any,
  output id_t               win
);
  rank_t rank;
  logic  found;

  assign rank = rank_of(code);
  assign any  = |elig;

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = 0; i < NLINES; i++) begin
      if (!found && elig[rank[i]]) begin
        win   = rank[i];
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_vc_pkg::*;
#(
  parameter int TOTAL    = 57,
  parameter int OFS_PCLO = 16,
  parameter int OFS_PCHI = 32,
  parameter int OFS_FLG  = 48,
  parameter int OFS_VHI  = 52,
  parameter int OFS_VLO  = 56,
  parameter int VEC_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  id_t              start_id,
  output logic             busy,
  output id_t              id_q,
  output logic [VEC_W-1:0] vec_addr,
  output logic             push_pc_lo,
  output logic             push_pc_hi,
  output logic             push_flags,
  output logic             fetch_vec_hi,
  output logic             fetch_vec_lo,
  output logic             done
);
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_n = cnt_q;
    if (start)                             cnt_n = CNT_W'(1);
    else if (cnt_q == CNT_W'(TOTAL))       cnt_n = '0;
    else if (busy)                         cnt_n = cnt_q + CNT_W'(1);
  end
  assign cnt_en = start | busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      id_q  <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_n;
      if (start)  id_q  <= start_id;
    end
  end

  assign push_pc_lo   = (cnt_q == CNT_W'(OFS_PCLO));
  assign push_pc_hi   = (cnt_q == CNT_W'(OFS_PCHI));
  assign push_flags   = (cnt_q == CNT_W'(OFS_FLG));
  assign fetch_vec_hi = (cnt_q == CNT_W'(OFS_VHI));
  assign fetch_vec_lo = (cnt_q == CNT_W'(OFS_VLO));
  assign done         = (cnt_q == CNT_W'(TOTAL));

  assign vec_addr = VEC_W'({id_q, 1'b0}) | VEC_W'(fetch_vec_lo);

  // R7: at most one phase strobe per cycle.
  p_one_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_pc_lo, push_pc_hi, push_flags, fetch_vec_hi, fetch_vec_lo, done}));

  // R7: the sequence ends right after done.
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R8: low vector byte sits at the odd address, high byte at the even one.
  p_vec_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vec_lo |-> vec_addr[0]) and (fetch_vec_hi |-> !vec_addr[0]));

  // R9: no restart while running.
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vc_pkg::*;
#(
  parameter int TOTAL    = 57,
  parameter int OFS_PCLO = 16,
  parameter int OFS_PCHI = 32,
  parameter int OFS_FLG  = 48,
  parameter int OFS_VHI  = 52,
  parameter int OFS_VLO  = 56,
  parameter int VEC_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_evt,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             insn_end,
  output logic             busy,
  output logic [ID_W-1:0]  grant_id,
  output logic [VEC_W-1:0] vec_addr,
  output logic             push_pc_lo,
  output logic             push_pc_hi,
  output logic             push_flags,
  output logic             fetch_vec_hi,
  output logic             fetch_vec_lo,
  output logic             done
);
  logic [1:0]        rs_q;
  logic              rst_n_s;
  logic [NLINES-1:0] req_q;
  logic [NLINES-1:0] mask_q;
  logic              gie_q;
  logic [PRIO_W-1:0] prio_q;
  logic [NLINES-1:0] elig;
  logic              any_elig;
  id_t               win_id;
  id_t               id_q;
  logic              grant;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  irq_req_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .src_evt    (src_evt),
    .wr_req     (reg_wr && reg_sel == 2'd0),
    .wr_mask    (reg_wr && reg_sel == 2'd1),
    .wr_prio    (reg_wr && reg_sel == 2'd2),
    .wdata      (reg_wdata),
    .grant      (grant),
    .grant_line (win_id),
    .req_q      (req_q),
    .mask_q     (mask_q),
    .gie_q      (gie_q),
    .prio_q     (prio_q)
  );

  assign elig = req_q & mask_q & {NLINES{gie_q}};

  irq_prio_sel u_sel (
    .elig (elig),
    .code (prio_q),
    .any  (any_elig),
    .win  (win_id)
  );

  assign grant = insn_end & any_elig & ~busy;

  irq_ack_seq #(
    .TOTAL(TOTAL), .OFS_PCLO(OFS_PCLO), .OFS_PCHI(OFS_PCHI), .OFS_FLG(OFS_FLG),
    .OFS_VHI(OFS_VHI), .OFS_VLO(OFS_VLO), .VEC_W(VEC_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start        (grant),
    .start_id     (win_id),
    .busy         (busy),
    .id_q         (id_q),
    .vec_addr     (vec_addr),
    .push_pc_lo   (push_pc_lo),
    .push_pc_hi   (push_pc_hi),
    .push_flags   (push_flags),
    .fetch_vec_hi (fetch_vec_hi),
    .fetch_vec_lo (fetch_vec_lo),
    .done         (done)
  );

  assign grant_id = id_q;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = 8'(req_q);
      2'd1:    reg_rdata = {gie_q, 1'b0, mask_q};
      2'd2:    reg_rdata = 8'(prio_q);
      default: reg_rdata = '0;
    endcase
  end

  // R4: the selector only ever picks an eligible line.
  p_grant_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    grant |-> (elig[win_id] && gie_q && mask_q[win_id]));

  // R6: a grant shuts the global enable.
  p_grant_clears_gie_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    grant |=> !gie_q);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] src_evt;
  logic       reg_wr;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       insn_end;
  logic       busy;
  logic [2:0] grant_id;
  logic [7:0] vec_addr;
  logic       push_pc_lo, push_pc_hi, push_flags, fetch_vec_hi, fetch_vec_lo, done;

  int checks = 0;
  int failures = 0;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .insn_end(insn_end), .busy(busy),
    .grant_id(grant_id), .vec_addr(vec_addr), .push_pc_lo(push_pc_lo),
    .push_pc_hi(push_pc_hi), .push_flags(push_flags), .fetch_vec_hi(fetch_vec_hi),
    .fetch_vec_lo(fetch_vec_lo), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  // Independent priority model: lowest score wins.
  function automatic int model_win(input logic [5:0] code, input logic [5:0] el);
    int pos [3];
    int best, bestscore, sc, g;
    bit valid;
    valid = 1'b1;
    case (code[2:0])
      3'd1: begin pos[0]=0; pos[1]=1; pos[2]=2; end
      3'd2: begin pos[0]=0; pos[2]=1; pos[1]=2; end
      3'd3: begin pos[1]=0; pos[0]=1; pos[2]=2; end
      3'd4: begin pos[1]=0; pos[2]=1; pos[0]=2; end
      3'd5: begin pos[2]=0; pos[0]=1; pos[1]=2; end
      3'd6: begin pos[2]=0; pos[1]=1; pos[0]=2; end
      default: begin valid = 1'b0; pos[0]=0; pos[1]=1; pos[2]=2; end
    endcase
    best = -1; bestscore = 100;
    for (int ln = 0; ln < 6; ln++) begin
      if (el[ln]) begin
        g = ln / 2;
        if (valid) sc = pos[g]*2 + ((ln % 2) ^ int'(code[3+g]));
        else       sc = ln;
        if (sc < bestscore) begin bestscore = sc; best = ln; end
      end
    end
    return best;
  endfunction

  // Full grant and sequence; disturb injects a mid-sequence strobe (R9).
  task automatic run_seq(input logic [5:0] reqv, input logic [5:0] code, input bit disturb);
    int w;
    logic [7:0] d;
    logic [5:0] exp_strb, act_strb;
    int bad;
    w = model_win(code, reqv);
    wr(2'd0, {2'b00, reqv});
    wr(2'd2, {2'b00, code});
    wr(2'd1, 8'hBF);
    @(negedge clk);
    insn_end = 1'b1;
    bad = 0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (k == 1) insn_end = 1'b0;
      if (disturb && k == 5) begin
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 8'hBF; insn_end = 1'b1;
      end
      if (disturb && k == 6) begin
        reg_wr = 1'b0; insn_end = 1'b0;
      end
      #1;
      exp_strb = {k == 16, k == 32, k == 48, k == 52, k == 56, k == 57};
      act_strb = {push_pc_lo, push_pc_hi, push_flags, fetch_vec_hi, fetch_vec_lo, done};
      if (act_strb != exp_strb || busy != (k <= 57)) begin
        if (bad == 0) chk(1'b0, disturb ? "R9 timing" : "R7 strobe timing", int'(act_strb), int'(exp_strb));
        bad++;
      end
      if (k == 1)  chk(grant_id == 3'(w), "R5 winner", grant_id, w);
      if (k == 52) chk(vec_addr == 8'(2*w), "R8 vector hi addr", vec_addr, 2*w);
      if (k == 56) chk(vec_addr == 8'(2*w+1), "R8 vector lo addr", vec_addr, 2*w+1);
      if (disturb && k == 57) chk(grant_id == 3'(w), "R9 grant_id kept", grant_id, w);
    end
    if (bad == 0) chk(1'b1, "R7 strobe timing", 0, 0);
    rd(2'd0, d);
    chk(d[5:0] == (reqv & ~(6'd1 << w)), "R6 request cleared", d, reqv & ~(6'd1 << w));
    rd(2'd1, d);
    chk(d == (disturb ? 8'hBF : 8'h3F), disturb ? "R9 enable write" : "R6 enable cleared",
        d, disturb ? 8'hBF : 8'h3F);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk(d == 8'h00, "R10 request reset", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R10 mask reset", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R10 prio reset", d, 0);
    chk({busy, grant_id, push_pc_lo, push_pc_hi, push_flags, fetch_vec_hi, fetch_vec_lo, done} == '0,
        "R10 outputs idle", int'(busy), 0);
  endtask

  task automatic t_hw_set();
    logic [7:0] d;
    @(negedge clk); src_evt = 8'b0101_0000;   // rx -> line3, timer0 -> line4
    @(negedge clk); src_evt = 8'b1000_0001;   // timer1 -> line5, pin0 -> line0
    rd(2'd0, d);
    chk(d == 8'h39, "R1 source mapping", d, 8'h39);
    src_evt = 8'h00;
    wr(2'd0, 8'h00);
    @(negedge clk); src_evt = 8'b0000_1000;   // pin3 held high
    wr(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    rd(2'd0, d);
    chk(d == 8'h00, "R1 level does not re-set", d, 0);
    src_evt = 8'h00;
  endtask

  task automatic t_sw_write();
    logic [7:0] d;
    wr(2'd0, 8'h2A); rd(2'd0, d); chk(d == 8'h2A, "R2 sw set", d, 8'h2A);
    wr(2'd0, 8'hD5); rd(2'd0, d); chk(d == 8'h15, "R2 sw set/clear", d, 8'h15);
    wr(2'd2, 8'hE9); rd(2'd2, d); chk(d == 8'h29, "R5 prio readback", d, 8'h29);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr(2'd0, 8'h01);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h00; src_evt = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0; src_evt = 8'h00;
    #1 d = reg_rdata;
    chk(d == 8'h01, "R3 hw set beats sw clear", d, 1);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(2'd0, 8'h3F);
    wr(2'd1, 8'h80);                 // enabled, all lines masked
    @(negedge clk); insn_end = 1'b1;
    @(negedge clk); insn_end = 1'b0;
    #1 chk(!busy, "R4 masked not granted", busy, 0);
    wr(2'd1, 8'h3F);                 // mask open, global off
    @(negedge clk); insn_end = 1'b1;
    @(negedge clk); insn_end = 1'b0;
    #1 chk(!busy, "R4 global off blocks", busy, 0);
    rd(2'd0, d);
    chk(d == 8'h3F, "R4 masked stays visible", d, 8'h3F);
    wr(2'd1, 8'hBF);                 // enabled but no strobe
    repeat (3) @(negedge clk);
    #1 chk(!busy, "R6 no grant without insn_end", busy, 0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_evt = '0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0; insn_end = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hw_set();
    t_sw_write();
    t_collision();
    t_mask();
    run_seq(6'h3F, 6'b000000, 1'b0);   // fallback -> line 0
    run_seq(6'h30, 6'b000111, 1'b0);   // code 7 fallback -> line 4
    run_seq(6'h31, 6'b000100, 1'b0);   // G1>G2>G0 -> line 4
    run_seq(6'h31, 6'b100100, 1'b0);   // G2 swapped -> line 5
    run_seq(6'h0C, 6'b010110, 1'b0);   // G2>G1>G0, G1 swapped -> line 3
    run_seq(6'h03, 6'b001011, 1'b0);   // G1>G0>G2, G0 swapped -> line 1
    run_seq(6'h24, 6'b000010, 1'b1);   // R9 disturb mid-sequence
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule